// File: doc/BRIEF.md
# Rotating Two-Stage Load-Balanced Cell Switch

This block switches fixed-size cells between N ports without any arbiter. Two stages of fixed permutations rotate once per time slot. The first stage spreads each input's cells across N middle ports. Each middle port holds one first-in first-out queue per destination output. The second stage rotates independently and visits every output once every N slots. On each visit, the queue for that output sends its head cell.

Both stages share one slot counter that wraps modulo N. Every path inside carries at most one cell per slot per port, so nothing runs faster than the line rate. Each cell is a valid bit, a binary destination index and a data word. Overflow at a middle queue discards the cell and counts it against that middle port.

The first clock edge after reset is released is a settling edge. On that edge the slot counter holds its value and input cells are ignored.

Top module: `lbSwitch`

## Requirements
- R1: `slotIdx` is 0 after reset and stays 0 across the first edge after release. After that it increments on every edge and wraps from N-1 to 0.
- R2: In slot t, a valid cell on input i is written into middle port (i + t) mod N. It enters that middle port's queue for the output named by its destination field.
- R3: In slot t, middle port k serves output (k + t) mod N. If that queue holds a cell, its head appears on the output with `outValid` high and its data, one edge later.
- R4: A cell never departs in the slot it arrives. It leaves in the first later slot that connects its middle port to its destination, which is 1 to N slots after arrival.
- R5: When the queue selected for an output is empty, that output's `outValid` is low in the following cycle.
- R6: Cells in any one queue leave in arrival order.
- R7: Each queue holds QD cells. A cell is dropped if its queue already holds QD cells before that slot's departure, even if a departure happens in the same slot. Each drop raises that middle port's `dropCount` field by exactly 1, and no other field changes.
- R8: During reset all outputs are invalid, all queues are empty and all drop counts are 0. Cells offered on the settling edge are ignored.
- R9: Input i's destination is `inDest[i*SW +: SW]`, a binary output index with SW = clog2(N). Its data is `inData[i*DW +: DW]`. Output j's data is `outData[j*DW +: DW]`. Middle port k's drop count is `dropCount[k*CW +: CW]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | N | Cell present on each input |
| inDest | input | N*SW | Destination output index per input |
| inData | input | N*DW | Cell data per input |
| outValid | output | N | Cell present on each output |
| outData | output | N*DW | Cell data per output |
| slotIdx | output | SW | Current time slot |
| dropCount | output | N*CW | Wrapping drop counter per middle port |

## Verification
An input cell is consumed at the edge that ends its slot. The earliest it can show at an output is one edge after the later slot in which its queue is selected, so the output delay runs from 2 to N+1 edges. Drop counts and the slot index change at the same edge as the arrival that caused them. The bench drives inputs on falling edges and steps a queue model at each rising edge. It samples every output at the next falling edge, so each comparison lands in the cycle its result is due. A directed case counts the exact slots between one cell's arrival and its departure.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  // Strobes sent from the slot control to the datapath.
  typedef struct packed {
    logic live;  // low on the settling edge after reset
  } slotStrobe_t;
endpackage

// File: rtl/lbsSlotCtl.sv
module lbsSlotCtl #(
  parameter int N = 4,
  parameter int SW = 2
) (
  input  logic clk,
  input  logic rstN,
  output logic [SW-1:0] slot,
  output lbs_pkg::slotStrobe_t strobe
);
  logic live;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      live <= 1'b0;
      slot <= '0;
    end else begin
      live <= 1'b1;
      if (live) slot <= (slot == SW'(N - 1)) ? '0 : slot + 1'b1;
    end
  end

  assign strobe.live = live;
endmodule

// File: rtl/lbsMidPort.sv
module lbsMidPort #(
  parameter int N = 4,
  parameter int DW = 8,
  parameter int QD = 4,
  parameter int CW = 8,
  parameter int SW = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic live,
  input  logic pushValid,
  input  logic [SW-1:0] pushDest,
  input  logic [DW-1:0] pushData,
  input  logic [SW-1:0] popSel,
  output logic popValid,
  output logic [DW-1:0] popData,
  output logic [CW-1:0] dropCnt
);
  localparam int CNTW = $clog2(QD + 1);
  localparam int AW = (QD > 1) ? $clog2(QD) : 1;

  logic [CNTW-1:0] cnt [N];
  logic [DW-1:0] head [N];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(QD - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar d = 0; d < N; d++) begin : g_voq
    logic [DW-1:0] mem [QD];
    logic [AW-1:0] wp, rp;
    logic [CNTW-1:0] occ;
    logic doPush, doPop;

    assign doPush = live && pushValid && (pushDest == SW'(d)) && (occ != CNTW'(QD));
    assign doPop = live && (popSel == SW'(d)) && (occ != '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wp <= '0;
        rp <= '0;
        occ <= '0;
      end else begin
        if (doPush) wp <= bump(wp);
        if (doPop) rp <= bump(rp);
        if (doPush && !doPop) occ <= occ + 1'b1;
        else if (doPop && !doPush) occ <= occ - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (doPush) mem[wp] <= pushData;
    end

    assign cnt[d] = occ;
    assign head[d] = mem[rp];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dropCnt <= '0;
    else if (live && pushValid && (cnt[pushDest] == CNTW'(QD))) dropCnt <= dropCnt + 1'b1;
  end

  assign popValid = (cnt[popSel] != '0);
  assign popData = head[popSel];
endmodule

// File: rtl/lbsFabric.sv
module lbsFabric #(
  parameter int N = 4,
  parameter int DW = 8,
  parameter int QD = 4,
  parameter int CW = 8,
  parameter int SW = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic [SW-1:0] slot,
  input  lbs_pkg::slotStrobe_t strobe,
  input  logic [N-1:0] inValid,
  input  logic [N*SW-1:0] inDest,
  input  logic [N*DW-1:0] inData,
  output logic [N-1:0] outValid,
  output logic [N*DW-1:0] outData,
  output logic [N*CW-1:0] dropCount
);
  logic [N-1:0] popV;
  logic [N-1:0][DW-1:0] popD;

  for (genvar k = 0; k < N; k++) begin : g_mid
    logic [SW-1:0] srcSel, dstSel;

    always_comb begin
      srcSel = SW'((k + N - int'(slot)) % N);
      dstSel = SW'((k + int'(slot)) % N);
    end

    lbsMidPort #(.N(N), .DW(DW), .QD(QD), .CW(CW), .SW(SW)) u_mid (
      .clk(clk),
      .rstN(rstN),
      .live(strobe.live),
      .pushValid(inValid[srcSel]),
      .pushDest(inDest[srcSel*SW +: SW]),
      .pushData(inData[srcSel*DW +: DW]),
      .popSel(dstSel),
      .popValid(popV[k]),
      .popData(popD[k]),
      .dropCnt(dropCount[k*CW +: CW])
    );
  end

  for (genvar j = 0; j < N; j++) begin : g_out
    logic [SW-1:0] midSel;

    always_comb midSel = SW'((j + N - int'(slot)) % N);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outValid[j] <= 1'b0;
        outData[j*DW +: DW] <= '0;
      end else if (strobe.live) begin
        outValid[j] <= popV[midSel];
        outData[j*DW +: DW] <= popD[midSel];
      end
    end
  end
endmodule

// File: rtl/lbSwitch.sv
module lbSwitch #(
  parameter int N = 4,
  parameter int DW = 8,
  parameter int QD = 4,
  parameter int CW = 8,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic [N-1:0] inValid,
  input  logic [N*SW-1:0] inDest,
  input  logic [N*DW-1:0] inData,
  output logic [N-1:0] outValid,
  output logic [N*DW-1:0] outData,
  output logic [SW-1:0] slotIdx,
  output logic [N*CW-1:0] dropCount
);
  lbs_pkg::slotStrobe_t strobe;

  lbsSlotCtl #(.N(N), .SW(SW)) u_ctl (
    .clk(clk),
    .rstN(rstN),
    .slot(slotIdx),
    .strobe(strobe)
  );

  lbsFabric #(.N(N), .DW(DW), .QD(QD), .CW(CW), .SW(SW)) u_fab (
    .clk(clk),
    .rstN(rstN),
    .slot(slotIdx),
    .strobe(strobe),
    .inValid(inValid),
    .inDest(inDest),
    .inData(inData),
    .outValid(outValid),
    .outData(outData),
    .dropCount(dropCount)
  );
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
  parameter int N = 4,
  parameter int SW = 2,
  parameter int CW = 8
) (
  input logic clk,
  input logic rstN,
  input logic [SW-1:0] slotIdx,
  input logic [N-1:0] inValid,
  input logic [N-1:0] outValid,
  input logic [N*CW-1:0] dropCount
);
  // R1
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotIdx == SW'(N - 1)) |=> (slotIdx == '0));

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotIdx != SW'(N - 1)) |=>
      ((slotIdx == $past(slotIdx)) || (slotIdx == SW'($past(slotIdx) + 1'b1))));

  // R8
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (outValid == '0));

  for (genvar k = 0; k < N; k++) begin : g_drop
    // R7
    drop_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (dropCount[k*CW +: CW] == $past(dropCount[k*CW +: CW])) ||
      (dropCount[k*CW +: CW] == CW'($past(dropCount[k*CW +: CW]) + 1'b1)));

    // R7
    drop_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      (dropCount[k*CW +: CW] != $past(dropCount[k*CW +: CW])) |-> $past(|inValid));
  end
endmodule

bind lbSwitch lbs_checker #(.N(N), .SW(SW), .CW(CW)) u_lbs_chk (
  .clk(clk),
  .rstN(rstN),
  .slotIdx(slotIdx),
  .inValid(inValid),
  .outValid(outValid),
  .dropCount(dropCount)
);

// File: tb/tb_lbSwitch.sv
module tb_lbSwitch;
  localparam int N = 4;
  localparam int SW = 2;
  localparam int DW = 8;
  localparam int QD = 4;
  localparam int CW = 8;

  // Each entry: {dest3, dest2, dest1, dest0 (2 bits each), valid mask (4 bits)}
  localparam logic [11:0] VEC [16] = '{
    12'hE4F, 12'h00F, 12'h00F, 12'h00F, 12'h000, 12'h1BF, 12'hFF5, 12'h00A,
    12'hE4F, 12'h000, 12'h39C, 12'h001, 12'hFF3, 12'h000, 12'h00F, 12'hE41
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] inValid = '0;
  logic [N*SW-1:0] inDest = '0;
  logic [N*DW-1:0] inData = '0;
  logic [N-1:0] outValid;
  logic [N*DW-1:0] outData;
  logic [SW-1:0] slotIdx;
  logic [N*CW-1:0] dropCount;

  always #10 clk = ~clk;

  lbSwitch #(.N(N), .DW(DW), .QD(QD), .CW(CW)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDest(inDest), .inData(inData),
    .outValid(outValid), .outData(outData), .slotIdx(slotIdx), .dropCount(dropCount)
  );

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  // Queue model built from the requirements.
  logic [DW-1:0] mq [N][N][QD];
  int mc [N][N];
  int mdrop [N];
  int mSlot;
  bit mLive;
  logic [N-1:0] expV;
  logic [DW-1:0] expD [N];

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelClear();
    for (int k = 0; k < N; k++) begin
      mdrop[k] = 0;
      for (int d = 0; d < N; d++) mc[k][d] = 0;
    end
    for (int j = 0; j < N; j++) begin
      expV[j] = 1'b0;
      expD[j] = '0;
    end
    mSlot = 0;
    mLive = 0;
  endtask

  task automatic modelStep(input logic [N-1:0] v, input logic [N*SW-1:0] dst,
                           input logic [N*DW-1:0] dat);
    int pre [N][N];
    if (!mLive) begin
      mLive = 1;  // settling edge: R8
      return;
    end
    for (int k = 0; k < N; k++)
      for (int d = 0; d < N; d++) pre[k][d] = mc[k][d];
    for (int j = 0; j < N; j++) begin
      int k;
      k = (j - mSlot + N) % N;  // R3
      if (pre[k][j] > 0) begin
        expV[j] = 1'b1;
        expD[j] = mq[k][j][0];
        for (int p = 0; p < QD - 1; p++) mq[k][j][p] = mq[k][j][p+1];
        mc[k][j]--;
      end else begin
        expV[j] = 1'b0;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (v[i]) begin
        int k, d;
        k = (i + mSlot) % N;  // R2
        d = int'(dst[i*SW +: SW]);
        if (pre[k][d] == QD) mdrop[k]++;  // R7
        else begin
          mq[k][d][mc[k][d]] = dat[i*DW +: DW];
          mc[k][d]++;
        end
      end
    end
    mSlot = (mSlot + 1) % N;
  endtask

  task automatic compareAll();
    check("R1 slot", int'(slotIdx), mSlot);
    for (int j = 0; j < N; j++) begin
      check(expV[j] ? "R3 valid" : "R5 idle", int'(outValid[j]), int'(expV[j]));
      // R9 field positions, R2 R6 routing and order
      if (expV[j]) check("R2 R6 data", int'(outData[j*DW +: DW]), int'(expD[j]));
    end
    for (int k = 0; k < N; k++)
      check("R7 drops", int'(dropCount[k*CW +: CW]), mdrop[k] % 256);
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic cycle(input logic [N-1:0] v, input logic [N*SW-1:0] dst,
                       input logic [N*DW-1:0] dat);
    inValid = v;
    inDest = dst;
    inData = dat;
    @(posedge clk);
    modelStep(v, dst, dat);
    @(negedge clk);
    inValid = '0;
    compareAll();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    inValid = '0;
    modelClear();
    repeat (2) @(negedge clk);
    // R8 reset state
    check("R8 reset valid", int'(outValid), 0);
    check("R8 reset slot", int'(slotIdx), 0);
    check("R8 reset drops", int'(dropCount), 0);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    modelClear();
    @(negedge clk);
    doReset();

    // R8: cells on the settling edge are ignored
    cycle('1, '0, {8'h11, 8'h22, 8'h33, 8'h44});
    check("R1 settle slot", int'(slotIdx), 0);
    for (int n = 0; n < 8; n++) begin
      cycle('0, '0, '0);
      check("R8 ignored cell", int'(outValid), 0);
    end

    // Table walk
    for (int r = 0; r < 6; r++) begin
      for (int idx = 0; idx < 16; idx++) begin
        logic [N*DW-1:0] dat;
        for (int i = 0; i < N; i++) dat[i*DW +: DW] = 8'(r * 64 + idx * 4 + i);
        cycle(VEC[idx][3:0], VEC[idx][11:4], dat);
      end
    end
    for (int n = 0; n < 24; n++) cycle('0, '0, '0);

    // R4: exact departure slot of a single cell, input 1 to output 2
    for (int trial = 0; trial < N; trial++) begin
      int t0, k, delay, seen;
      t0 = mSlot;
      k = (1 + t0) % N;
      delay = ((2 - k - t0) % N + 2 * N) % N;
      if (delay == 0) delay = N;
      cycle(4'b0010, 8'b0000_1000, {8'h00, 8'h00, 8'hA0 + 8'(trial), 8'h00});
      check("R4 no same-slot departure", int'(outValid[2]), 0);
      seen = 0;
      for (int n = 1; n <= N; n++) begin
        cycle('0, '0, '0);
        if (outValid[2] && seen == 0) seen = n;
      end
      check("R4 departure slot", seen, delay);
      cycle('0, '0, '0);  // shift the arrival slot for the next trial
    end

    // R7: hotspot overflow, then reset mid-run
    for (int n = 0; n < 12; n++) cycle('1, '0, {8'h5A, 8'h5B, 8'h5C, 8'h5D});
    doReset();
    cycle('0, '0, '0);
    for (int n = 0; n < 6; n++) cycle('0, '0, '0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule